// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the clock sent to an SD card from a faster base clock. Two counters run back to back in the base clock domain. The first is a power-of-two prescaler selected by a one-hot code. The second is a linear stage that divides the prescaler's ticks by one to sixteen. The card clock comes straight from a register and toggles once per half period, so it is always a clean square wave.

Software supplies the prescaler code, the divisor field and an enable bit. The block takes on new settings only at the end of a low phase, so a change never produces a short pulse. A prescaler code that does not have exactly one bit set stops the clock after its current high phase and raises an error flag. A one-cycle strobe marks each rising edge of the card clock. Logic in the base domain can use it as a clock enable.

Top module: `cardclk_gen`

## Requirements
- R1: With prescaler code P (one of 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, read as its numeric value) and divisor field N, each high phase and each low phase of `card_clk` lasts P×(N+1) base cycles. The total division is therefore 2×P×(N+1) and the duty cycle is 50%. The code 0x80 with N=0 divides by 256.
- R2: The 4-bit divisor field multiplies the half period linearly by N+1. N=0x0 gives ×1 and N=0xF gives ×16.
- R3: `rise_pulse` is high for exactly one base cycle: the first cycle in which `card_clk` is high after being low. At no other time is it high.
- R4: `presc_err` is high one base cycle after the prescaler code has zero bits or more than one bit set. It returns low one base cycle after the code is one-hot again.
- R5: While the prescaler code is illegal, a high phase already in progress completes at its full length. After that `card_clk` stays low and no new rising edge occurs.
- R6: When `clk_en` is low, a high phase already in progress completes at its full length. After that `card_clk` stays low with no strobes.
- R7: A change to the prescaler or divisor does not alter the high and low phases of the period in progress. The new values apply from the next rising edge.
- R8: While `rst_n` is low (synchronous, active low), `card_clk`, `rise_pulse` and `presc_err` are all 0 on the next edge. When the block is idle and sees `clk_en` high with a legal code, `card_clk` and `rise_pulse` go high on the next base clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 8 | One-hot prescaler code |
| div_sel | input | 4 | Linear divisor field N (divide by N+1) |
| clk_en | input | 1 | Card clock enable |
| card_clk | output | 1 | Divided card clock, registered |
| rise_pulse | output | 1 | One-cycle strobe on each card clock rising edge |
| presc_err | output | 1 | Illegal prescaler code flag |

## Verification
The assertions assume that `presc_sel`, `div_sel` and `clk_en` change only between base clock edges and hold steady across each edge, and that reset is held for at least one edge before any checked behaviour. The bench drives every input on the falling edge and keeps reset low for several cycles at the start. It changes settings only at known points in the card clock phase, so the lengths of the phases in progress and of the following phases can each be predicted.

// File: rtl/cardclk_pkg.sv
// Package: shared defaults and the phase-state type for the SD card clock divider.
// Assumes nothing beyond IEEE 1800-2017 package support.
package cardclk_pkg;

    // Default width of the one-hot prescaler code
    localparam int PRESC_W_DEF = 8;
    // Default width of the linear divisor field
    localparam int DIV_W_DEF   = 4;

    // Card clock phase tracker
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

endpackage

// File: rtl/cc_setting_check.sv
// Module: cc_setting_check
// Decides whether the prescaler code has exactly one bit set.
// Assumes: purely combinational; the caller registers the result if needed.
module cc_setting_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] code,
    output logic         legal
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] ones;

    // Count set bits and call the code legal only when exactly one is set
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(code[i]);
        end
        legal = (ones == CW'(1));
    end

endmodule

// File: rtl/cc_presc_stage.sv
// Module: cc_presc_stage
// First divider stage. It counts base cycles and raises tick on the
// last cycle of every group of `limit` cycles.
// Assumes: limit is non-zero and constant while adv is high within a group.
module cc_presc_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    // Terminal count: the group ends when the counter reaches limit-1
    assign tick = adv && (cnt_q == (limit - W'(1)));

    // Count base cycles; wrap at terminal, hold at zero while cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= tick ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/cc_div_stage.sv
// Module: cc_div_stage
// Second divider stage. It counts prescaler ticks and raises wrap on the
// tick that completes N+1 of them.
// Assumes: limit (N) is constant for the whole count.
module cc_div_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt_q;

    // Wrap when the last of N+1 ticks arrives
    assign wrap = adv && (cnt_q == limit);

    // Count ticks; wrap to zero, hold at zero while cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/cardclk_gen.sv
// Module: cardclk_gen (top)
// Generates the SD card clock by cascading a one-hot power-of-two prescaler
// with a linear divide-by-(N+1) stage. Each card clock phase lasts
// P*(N+1) base cycles. Settings are taken at the end of a low phase, or at
// once when idle. An illegal prescaler code or a low enable stops the clock
// after the current high phase.
// Assumes: inputs are synchronous to clk_base; rst_n is synchronous, active low.
module cardclk_gen
    import cardclk_pkg::*;
#(
    parameter int PRESC_W = PRESC_W_DEF,
    parameter int DIV_W   = DIV_W_DEF
) (
    input  logic               clk_base,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_sel,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic               clk_en,
    output logic               card_clk,
    output logic               rise_pulse,
    output logic               presc_err
);

    localparam logic [PRESC_W-1:0] PRESC_RST = PRESC_W'(1) << (PRESC_W - 1);
    localparam logic [DIV_W-1:0]   DIV_RST   = '0;

    phase_t             ph_q, ph_n;
    logic               card_q, card_n;
    logic               pulse_q;
    logic               err_q;
    logic               load;
    logic               sel_legal;
    logic               go;
    logic               running;
    logic               pre_tick;
    logic               div_wrap;
    logic [PRESC_W-1:0] presc_act;
    logic [DIV_W-1:0]   div_act;

    cc_setting_check #(.W(PRESC_W)) u_check (
        .code  (presc_sel),
        .legal (sel_legal)
    );

    // Running means the counters advance; idle holds them at zero
    assign running = (ph_q != PH_IDLE);
    assign go      = clk_en && sel_legal;

    cc_presc_stage #(.W(PRESC_W)) u_presc (
        .clk   (clk_base),
        .rst_n (rst_n),
        .clear (!running),
        .adv   (running),
        .limit (presc_act),
        .tick  (pre_tick)
    );

    cc_div_stage #(.W(DIV_W)) u_div (
        .clk   (clk_base),
        .rst_n (rst_n),
        .clear (!running),
        .adv   (pre_tick),
        .limit (div_act),
        .wrap  (div_wrap)
    );

    // Phase sequencing: start from idle, toggle on wrap, stop at low-phase end
    always_comb begin
        ph_n   = ph_q;
        card_n = card_q;
        load   = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (go) begin
                    ph_n   = PH_HIGH;
                    card_n = 1'b1;
                    load   = 1'b1;
                end
            end
            PH_HIGH: begin
                if (div_wrap) begin
                    ph_n   = PH_LOW;
                    card_n = 1'b0;
                end
            end
            PH_LOW: begin
                if (div_wrap) begin
                    if (go) begin
                        ph_n   = PH_HIGH;
                        card_n = 1'b1;
                        load   = 1'b1;
                    end else begin
                        ph_n   = PH_IDLE;
                    end
                end
            end
            default: begin
                ph_n   = PH_IDLE;
                card_n = 1'b0;
            end
        endcase
    end

    // Phase state, card clock and rising-edge strobe registers
    always_ff @(posedge clk_base) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            card_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            ph_q    <= ph_n;
            card_q  <= card_n;
            pulse_q <= card_n && !card_q;
        end
    end

    // Active settings, captured only at a safe boundary
    always_ff @(posedge clk_base) begin
        if (!rst_n) begin
            presc_act <= PRESC_RST;
            div_act   <= DIV_RST;
        end else if (load) begin
            presc_act <= presc_sel;
            div_act   <= div_sel;
        end
    end

    // Registered illegal-code flag
    always_ff @(posedge clk_base) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= !sel_legal;
        end
    end

    assign card_clk   = card_q;
    assign rise_pulse = pulse_q;
    assign presc_err  = err_q;

endmodule

// File: rtl/cardclk_chk.sv
// Module: cardclk_chk
// Assertion checker for cardclk_gen, attached with bind below.
// Assumes: inputs are stable across each rising edge of clk.
module cardclk_chk #(
    parameter int PRESC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PRESC_W-1:0] presc_sel,
    input logic               clk_en,
    input logic               card_clk,
    input logic               rise_pulse,
    input logic               presc_err
);

    // R3: every rising edge of card_clk comes with the strobe
    p_pulse_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> rise_pulse);

    // R3: the strobe appears only on a rising edge
    p_pulse_only_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> (card_clk && !$past(card_clk)));

    // R4: an illegal code raises the flag one cycle later
    p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(presc_sel) |=> presc_err);

    // R4: a legal code clears the flag one cycle later
    p_err_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(presc_sel) |=> !presc_err);

    // R5, R6: a rise requires enable and a legal code on the previous edge
    p_rise_needs_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> ($past(clk_en) && $onehot($past(presc_sel))));

    // R8: reset clears all outputs
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!card_clk && !rise_pulse && !presc_err));

endmodule

bind cardclk_gen cardclk_chk #(.PRESC_W(PRESC_W)) u_chk (
    .clk        (clk_base),
    .rst_n      (rst_n),
    .presc_sel  (presc_sel),
    .clk_en     (clk_en),
    .card_clk   (card_clk),
    .rise_pulse (rise_pulse),
    .presc_err  (presc_err)
);

// File: tb/cardclk_gen_test.sv
// Directed bench for cardclk_gen: one task per scenario, each checking itself.
module cardclk_gen_test;

    logic       clk_base = 1'b0;
    logic       rst_n    = 1'b0;
    logic [7:0] presc_sel = 8'h80;
    logic [3:0] div_sel   = 4'h0;
    logic       clk_en    = 1'b0;
    logic       card_clk;
    logic       rise_pulse;
    logic       presc_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    cardclk_gen uut (
        .clk_base   (clk_base),
        .rst_n      (rst_n),
        .presc_sel  (presc_sel),
        .div_sel    (div_sel),
        .clk_en     (clk_en),
        .card_clk   (card_clk),
        .rise_pulse (rise_pulse),
        .presc_err  (presc_err)
    );

    always #2 clk_base = ~clk_base;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk_base) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Advance to a falling edge where rise_pulse is high
    task automatic wait_rise(input int limit, output bit got);
        got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk_base);
            if (rise_pulse) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    // From a falling edge at a rise: count the high and low cycles and the strobes
    task automatic measure(output int hi, output int lo, output int pulses);
        hi = 1; lo = 0; pulses = 1;
        @(negedge clk_base);
        while (card_clk && hi < 20000) begin
            hi++;
            if (rise_pulse) pulses++;
            @(negedge clk_base);
        end
        while (!card_clk && lo < 20000) begin
            lo++;
            if (rise_pulse) pulses++;
            @(negedge clk_base);
        end
    endtask

    // Count cycles in which the clock is high or strobing over a window
    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_base);
            if (card_clk || rise_pulse) seen++;
        end
    endtask

    task automatic t_reset();
        int seen;
        presc_sel = 8'h03;
        clk_en    = 1'b1;
        repeat (4) @(negedge clk_base);
        chk(!card_clk, "R8 reset card_clk", card_clk, 0);
        chk(!rise_pulse, "R8 reset rise_pulse", rise_pulse, 0);
        chk(!presc_err, "R8 reset presc_err", presc_err, 0);
        clk_en    = 1'b0;
        presc_sel = 8'h80;
        rst_n     = 1'b1;
        quiet(20, seen);
        chk(seen == 0, "R6 disabled after reset stays low", seen, 0);
        clk_en = 1'b1;
        @(negedge clk_base);
        chk(card_clk && rise_pulse, "R8 start one cycle after enable", card_clk, 1);
    endtask

    task automatic t_ratio(input logic [7:0] p, input logic [3:0] n, input string req);
        bit got;
        int hi, lo, pulses, exp;
        presc_sel = p;
        div_sel   = n;
        clk_en    = 1'b1;
        exp = int'(p) * (int'(n) + 1);
        wait_rise(5000, got);
        chk(got, {req, " rise seen"}, got, 1);
        measure(hi, lo, pulses);
        chk(hi == exp, {req, " high phase"}, hi, exp);
        chk(lo == exp, {req, " low phase"}, lo, exp);
        chk(pulses == 1 && rise_pulse, "R3 one strobe per period", pulses, 1);
    endtask

    task automatic t_change();
        bit got;
        int hi, lo, pulses;
        presc_sel = 8'h02;
        div_sel   = 4'h0;
        wait_rise(5000, got);
        wait_rise(50, got);
        div_sel = 4'h4;
        measure(hi, lo, pulses);
        chk(hi == 2 && lo == 2, "R7 period in progress keeps old setting", hi + lo, 4);
        measure(hi, lo, pulses);
        chk(hi == 10 && lo == 10, "R7 new setting from next rise", hi + lo, 20);
    endtask

    task automatic t_disable();
        bit got;
        int hi, seen;
        presc_sel = 8'h04;
        div_sel   = 4'h1;
        wait_rise(5000, got);
        wait_rise(50, got);
        clk_en = 1'b0;
        hi = 1;
        @(negedge clk_base);
        while (card_clk && hi < 100) begin
            hi++;
            @(negedge clk_base);
        end
        chk(hi == 8, "R6 high phase completes when disabled", hi, 8);
        quiet(100, seen);
        chk(seen == 0, "R6 clock stays low when disabled", seen, 0);
        clk_en = 1'b1;
        @(negedge clk_base);
        chk(card_clk && rise_pulse, "R8 restart one cycle after enable", card_clk, 1);
    endtask

    task automatic t_illegal();
        bit got;
        int hi, seen;
        wait_rise(5000, got);
        presc_sel = 8'h06;
        hi = 1;
        @(negedge clk_base);
        chk(presc_err, "R4 flag one cycle after multi-bit code", presc_err, 1);
        while (card_clk && hi < 100) begin
            hi++;
            @(negedge clk_base);
        end
        chk(hi == 8, "R5 high phase completes with illegal code", hi, 8);
        quiet(100, seen);
        chk(seen == 0, "R5 clock held low while illegal", seen, 0);
        presc_sel = 8'h00;
        @(negedge clk_base);
        chk(presc_err && !card_clk, "R4 flag for all-zero code", presc_err, 1);
        presc_sel = 8'h04;
        @(negedge clk_base);
        chk(!presc_err, "R4 flag clears one cycle after legal code", presc_err, 0);
        chk(card_clk && rise_pulse, "R5 clock resumes with legal code", card_clk, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk_base);
        t_reset();
        t_ratio(8'h80, 4'h0, "R1 default /256");
        t_ratio(8'h01, 4'h0, "R1 minimum /2");
        t_ratio(8'h10, 4'h3, "R1 code 0x10 N=3");
        t_ratio(8'h01, 4'hF, "R2 N=15");
        t_ratio(8'h04, 4'hE, "R2 code 0x04 N=14");
        t_ratio(8'h80, 4'hF, "R2 maximum");
        t_change();
        t_disable();
        t_illegal();
        finish_run();
    end

endmodule